// File: doc/BRIEF.md
# SIMD Lane Array with Scalar Boundary Routing

This block is a row of identical datapath lanes that all obey one shared control segment in every cycle. Each lane holds a registered adder unit, a registered multiplier unit, a small register file and its own operand multiplexers. Each lane also receives a constant lane number. The array is used beside scalar units that only deal in whole words. Vector words from those units, or a single scalar value, reach the lanes through an outer selector, and lane results come back to them as packed vectors.

Every lane input port draws its operand in two steps. First an outer selector picks a full-width vector from the scalar side: vector A, vector B, a scalar replicated into every element, or zero. The vector is cut into elements, and lane i gets element i. Then a local selector inside the lane picks either that element or one of the lane's own results (adder, multiplier, register file read). Local paths never leave the lane. The one-bit compare results of all lanes are packed into a flag word, one bit per lane, that a scalar unit can read as an ordinary integer.

Top module: `simd_slice_array`

## Requirements
- R1: While rst_ni is low, add_vec_o, mul_vec_o, rf_vec_o and flag_o are all zero, and every register file entry is cleared.
- R2: The control segment seg_i is packed MSB first as: add_op[2], rf_we[1], rf_waddr[2], rf_raddr[2], then five source selects, one per lane input port, in the order rf write data, mul B, mul A, add B, add A (add A in the lowest bits). Each select is {outer[2], local[2]}. In all vectors, lane i uses bits [i*W +: W]. With add_op 0 (add) or 1 (subtract), each lane's add_vec_o element is A+B or A-B modulo 2^W, one clock after the segment is applied.
- R3: With add_op 2 (compare), flag_o bit i is 1 exactly when lane i's A is less than B as signed W-bit values. That lane's add_vec_o element is then the flag zero-extended.
- R4: With add_op 3 (lane number), lane i's add_vec_o element becomes i one clock later.
- R5: In every cycle, each lane's mul_vec_o element becomes the low W bits of A*B one clock later.
- R6: Outer select 2 delivers scal_i unchanged to every lane, and outer select 0 and 1 deliver the lane's own element of vec_a_i and vec_b_i.
- R7: Outer select 3 delivers zero to every lane.
- R8: Local select 0 takes the outer element. Selects 1, 2 and 3 take the lane's own registered adder result, its own registered multiplier result, and its own register file read data at rf_raddr. No value crosses between lanes.
- R9: With rf_we 1, every lane writes its write-data operand at rf_waddr on the clock edge. rf_vec_o shows each lane's entry at rf_raddr, so a read of the address just written shows the new data after that edge. With rf_we 0, no entry changes.
- R10: flag_o is all zero one clock after any add_op other than compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_i | input | 27 | Shared control segment (layout in R2) |
| vec_a_i | input | N*W | Vector word A from scalar side |
| vec_b_i | input | N*W | Vector word B from scalar side |
| scal_i | input | W | Scalar operand for broadcast |
| add_vec_o | output | N*W | Merged registered adder results |
| mul_vec_o | output | N*W | Merged registered multiplier results |
| rf_vec_o | output | N*W | Merged register file read data |
| flag_o | output | N | Compare flags, bit i from lane i |

## Verification
The bench builds the array with its default parameters: four lanes of 16-bit elements. With four lanes, mixed flag patterns such as 0101 can be told apart from a shifted or reversed packing, and the lane-number opcode reaches the highest index 3. The 16-bit width lets operands sit at the signed extremes 0x8000 and 0x7FFF, where a signed compare and an unsigned compare disagree and where sums and products wrap. A reference model in the bench tracks every lane register and register file entry, so local feedback paths can be chained over several cycles.

// File: rtl/simd_arr_pkg.sv
package simd_arr_pkg;
  localparam int unsigned NUM_PORTS = 5;
  localparam int unsigned RF_DEPTH  = 4;
  localparam int unsigned RF_AW     = $clog2(RF_DEPTH);

  // lane input port index into the source select array
  localparam int unsigned P_ADD_A = 0;
  localparam int unsigned P_ADD_B = 1;
  localparam int unsigned P_MUL_A = 2;
  localparam int unsigned P_MUL_B = 3;
  localparam int unsigned P_RF_WD = 4;

  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_SLT = 2'd2, OP_IDX = 2'd3} add_op_e;
  typedef enum logic [1:0] {OUT_VA = 2'd0, OUT_VB = 2'd1, OUT_BC = 2'd2, OUT_ZERO = 2'd3} outer_sel_e;
  typedef enum logic [1:0] {LOC_EXT = 2'd0, LOC_ADD = 2'd1, LOC_MUL = 2'd2, LOC_RF = 2'd3} local_sel_e;

  typedef struct packed {
    outer_sel_e outer;
    local_sel_e loc;
  } src_sel_t;

  typedef struct packed {
    add_op_e                       add_op;
    logic                          rf_we;
    logic [RF_AW-1:0]              rf_waddr;
    logic [RF_AW-1:0]              rf_raddr;
    src_sel_t [NUM_PORTS-1:0]      src;
  } seg_t;

  localparam int unsigned SEG_W = $bits(seg_t);
endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add
  import simd_arr_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned IDW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  add_op_e        op_i,
  input  logic [IDW-1:0] lane_id_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic           flag_o
);
  logic [W-1:0] res_d;
  logic         lt;

  always_comb begin
    lt = $signed(a_i) < $signed(b_i);
    case (op_i)
      OP_ADD:  res_d = a_i + b_i;
      OP_SUB:  res_d = a_i - b_i;
      OP_SLT:  res_d = {{(W-1){1'b0}}, lt};
      default: res_d = W'(lane_id_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      res_o  <= res_d;
      flag_o <= (op_i == OP_SLT) && lt;
    end
  end
endmodule

// File: rtl/simd_lane_mul.sv
module simd_lane_mul #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= a_i * b_i;
  end
endmodule

// File: rtl/simd_lane_rf.sv
module simd_lane_rf #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/simd_slice.sv
module simd_slice
  import simd_arr_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned IDW = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  seg_t                         seg_i,
  input  logic [IDW-1:0]               lane_id_i,
  input  logic [NUM_PORTS-1:0][W-1:0]  ext_i,
  output logic [W-1:0]                 add_o,
  output logic [W-1:0]                 mul_o,
  output logic [W-1:0]                 rf_o,
  output logic                         flag_o
);
  logic [NUM_PORTS-1:0][W-1:0] opnd;

  // local (second-level) operand selection, lane-private paths only
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_loc
    always_comb begin
      case (seg_i.src[p].loc)
        LOC_EXT: opnd[p] = ext_i[p];
        LOC_ADD: opnd[p] = add_o;
        LOC_MUL: opnd[p] = mul_o;
        default: opnd[p] = rf_o;
      endcase
    end
  end

  simd_lane_add #(.W(W), .IDW(IDW)) u_add (
    .clk_i, .rst_ni,
    .op_i      (seg_i.add_op),
    .lane_id_i (lane_id_i),
    .a_i       (opnd[P_ADD_A]),
    .b_i       (opnd[P_ADD_B]),
    .res_o     (add_o),
    .flag_o    (flag_o)
  );

  simd_lane_mul #(.W(W)) u_mul (
    .clk_i, .rst_ni,
    .a_i   (opnd[P_MUL_A]),
    .b_i   (opnd[P_MUL_B]),
    .res_o (mul_o)
  );

  simd_lane_rf #(.W(W), .DEPTH(RF_DEPTH)) u_rf (
    .clk_i, .rst_ni,
    .we_i    (seg_i.rf_we),
    .waddr_i (seg_i.rf_waddr),
    .wdata_i (opnd[P_RF_WD]),
    .raddr_i (seg_i.rf_raddr),
    .rdata_o (rf_o)
  );
endmodule

// File: rtl/simd_slice_array.sv
module simd_slice_array
  import simd_arr_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned W = 16,
  localparam int unsigned VW  = N * W,
  localparam int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [VW-1:0]    vec_a_i,
  input  logic [VW-1:0]    vec_b_i,
  input  logic [W-1:0]     scal_i,
  output logic [VW-1:0]    add_vec_o,
  output logic [VW-1:0]    mul_vec_o,
  output logic [VW-1:0]    rf_vec_o,
  output logic [N-1:0]     flag_o
);
  seg_t seg;
  assign seg = seg_t'(seg_i);

  // outer (first-level) selection: scalar-side sources only
  logic [NUM_PORTS-1:0][VW-1:0] outer_vec;
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_outer
    always_comb begin
      case (seg.src[p].outer)
        OUT_VA:  outer_vec[p] = vec_a_i;
        OUT_VB:  outer_vec[p] = vec_b_i;
        OUT_BC:  outer_vec[p] = {N{scal_i}};
        default: outer_vec[p] = '0;
      endcase
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [NUM_PORTS-1:0][W-1:0] ext;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_split
      assign ext[p] = outer_vec[p][i*W +: W];
    end

    simd_slice #(.W(W), .IDW(IDW)) u_slice (
      .clk_i, .rst_ni,
      .seg_i     (seg),
      .lane_id_i (IDW'(i)),
      .ext_i     (ext),
      .add_o     (add_vec_o[i*W +: W]),
      .mul_o     (mul_vec_o[i*W +: W]),
      .rf_o      (rf_vec_o[i*W +: W]),
      .flag_o    (flag_o[i])
    );
  end
endmodule

// File: rtl/simd_slice_array_chk.sv
module simd_slice_array_chk
  import simd_arr_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned W = 16,
  localparam int unsigned VW = N * W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEG_W-1:0] seg_i,
  input logic [VW-1:0]    vec_a_i,
  input logic [VW-1:0]    vec_b_i,
  input logic [W-1:0]     scal_i,
  input logic [VW-1:0]    add_vec_o,
  input logic [VW-1:0]    mul_vec_o,
  input logic [VW-1:0]    rf_vec_o,
  input logic [N-1:0]     flag_o
);
  seg_t sg;
  assign sg = seg_t'(seg_i);

  p_flag_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sg.add_op != OP_SLT) |=> (flag_o == '0));

  p_rf_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sg.rf_we |=> ((sg.rf_raddr != $past(sg.rf_raddr)) || (rf_vec_o == $past(rf_vec_o))));

  p_rf_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sg.rf_we && sg.rf_waddr == sg.rf_raddr &&
     sg.src[P_RF_WD].outer == OUT_VA && sg.src[P_RF_WD].loc == LOC_EXT)
    |=> ((sg.rf_raddr != $past(sg.rf_raddr)) || (rf_vec_o == $past(vec_a_i))));

  for (genvar i = 0; i < N; i++) begin : g_lane_chk
    p_lane_id_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sg.add_op == OP_IDX) |=> (add_vec_o[i*W +: W] == W'(i)));

    p_bcast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sg.add_op == OP_ADD &&
       sg.src[P_ADD_A].outer == OUT_BC   && sg.src[P_ADD_A].loc == LOC_EXT &&
       sg.src[P_ADD_B].outer == OUT_ZERO && sg.src[P_ADD_B].loc == LOC_EXT)
      |=> (add_vec_o[i*W +: W] == $past(scal_i)));

    p_mul_split_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sg.src[P_MUL_A].outer == OUT_VA && sg.src[P_MUL_A].loc == LOC_EXT &&
       sg.src[P_MUL_B].outer == OUT_VB && sg.src[P_MUL_B].loc == LOC_EXT)
      |=> (mul_vec_o[i*W +: W] == W'($past(vec_a_i[i*W +: W]) * $past(vec_b_i[i*W +: W]))));
  end
endmodule

bind simd_slice_array simd_slice_array_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/simd_slice_array_tb.sv
module simd_slice_array_tb;
  import simd_arr_pkg::*;

  localparam int unsigned N  = 4;
  localparam int unsigned W  = 16;
  localparam int unsigned VW = N * W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  seg_t             cur = '0;
  logic [SEG_W-1:0] seg_i;
  logic [VW-1:0]    vec_a = '0, vec_b = '0;
  logic [W-1:0]     scal = '0;
  logic [VW-1:0]    add_vec, mul_vec, rf_vec;
  logic [N-1:0]     flag;

  assign seg_i = cur;
  always #10 clk = ~clk;

  simd_slice_array #(.N(N), .W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .seg_i(seg_i),
    .vec_a_i(vec_a), .vec_b_i(vec_b), .scal_i(scal),
    .add_vec_o(add_vec), .mul_vec_o(mul_vec), .rf_vec_o(rf_vec), .flag_o(flag)
  );

  typedef struct {
    logic [VW-1:0] add;
    logic [VW-1:0] mul;
    logic [VW-1:0] rf;
    logic [N-1:0]  flag;
    string         req;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;

  // reference state
  logic [W-1:0] m_add [N];
  logic [W-1:0] m_mul [N];
  logic         m_flag[N];
  logic [W-1:0] m_rf  [N][RF_DEPTH];

  function automatic src_sel_t sel(outer_sel_e o, local_sel_e l);
    src_sel_t s;
    s.outer = o;
    s.loc   = l;
    return s;
  endfunction

  function automatic logic [W-1:0] pick(src_sel_t s, int ln, logic [RF_AW-1:0] ra,
                                        logic [VW-1:0] va, logic [VW-1:0] vb, logic [W-1:0] sc);
    logic [W-1:0] e;
    case (s.outer)
      OUT_VA:  e = va[ln*W +: W];
      OUT_VB:  e = vb[ln*W +: W];
      OUT_BC:  e = sc;
      default: e = '0;
    endcase
    case (s.loc)
      LOC_EXT: return e;
      LOC_ADD: return m_add[ln];
      LOC_MUL: return m_mul[ln];
      default: return m_rf[ln][ra];
    endcase
  endfunction

  task automatic check(string req, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: apply segment, advance the model, queue the expectation
  task automatic step(seg_t s, logic [VW-1:0] va, logic [VW-1:0] vb, logic [W-1:0] sc, string req);
    logic [W-1:0] na[N], nm[N], wd[N];
    logic         nf[N];
    exp_t         e;
    @(negedge clk);
    cur = s; vec_a = va; vec_b = vb; scal = sc;
    for (int ln = 0; ln < N; ln++) begin
      logic [W-1:0] a, b, ma, mb;
      a  = pick(s.src[P_ADD_A], ln, s.rf_raddr, va, vb, sc);
      b  = pick(s.src[P_ADD_B], ln, s.rf_raddr, va, vb, sc);
      ma = pick(s.src[P_MUL_A], ln, s.rf_raddr, va, vb, sc);
      mb = pick(s.src[P_MUL_B], ln, s.rf_raddr, va, vb, sc);
      wd[ln] = pick(s.src[P_RF_WD], ln, s.rf_raddr, va, vb, sc);
      nf[ln] = 1'b0;
      case (s.add_op)
        OP_ADD: na[ln] = a + b;
        OP_SUB: na[ln] = a - b;
        OP_SLT: begin nf[ln] = $signed(a) < $signed(b); na[ln] = W'(nf[ln]); end
        default: na[ln] = W'(ln);
      endcase
      nm[ln] = ma * mb;
    end
    for (int ln = 0; ln < N; ln++) begin
      m_add[ln] = na[ln]; m_mul[ln] = nm[ln]; m_flag[ln] = nf[ln];
      if (s.rf_we) m_rf[ln][s.rf_waddr] = wd[ln];
      e.add[ln*W +: W] = m_add[ln];
      e.mul[ln*W +: W] = m_mul[ln];
      e.rf [ln*W +: W] = m_rf[ln][s.rf_raddr];
      e.flag[ln]       = m_flag[ln];
    end
    e.req = req;
    q.push_back(e);
  endtask

  // monitor: compare mid-cycle after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, "add_vec", add_vec, e.add);
        check(e.req, "mul_vec", mul_vec, e.mul);
        check(e.req, "rf_vec",  rf_vec,  e.rf);
        check(e.req, "flag",    VW'(flag), VW'(e.flag));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    seg_t s;
    for (int ln = 0; ln < N; ln++) begin
      m_add[ln] = '0; m_mul[ln] = '0; m_flag[ln] = 1'b0;
      for (int k = 0; k < RF_DEPTH; k++) m_rf[ln][k] = '0;
    end
    #30;
    // R1: outputs cleared during reset
    check("R1", "add_vec", add_vec, '0);
    check("R1", "mul_vec", mul_vec, '0);
    check("R1", "rf_vec",  rf_vec,  '0);
    check("R1", "flag",    VW'(flag), '0);
    @(negedge clk); rst_ni = 1'b1;

    // R2 add with wrap, R5 multiply of split elements
    s = '0; s.add_op = OP_ADD;
    s.src[P_ADD_A] = sel(OUT_VA, LOC_EXT); s.src[P_ADD_B] = sel(OUT_VB, LOC_EXT);
    s.src[P_MUL_A] = sel(OUT_VA, LOC_EXT); s.src[P_MUL_B] = sel(OUT_VB, LOC_EXT);
    step(s, {16'hFFFF, 16'h1234, 16'h0100, 16'h0003}, {16'h0001, 16'h1111, 16'h0100, 16'h0005}, '0, "R2");
    step(s, {16'h8001, 16'h00FF, 16'h7FFF, 16'h0000}, {16'h0002, 16'h0101, 16'h0003, 16'hABCD}, '0, "R5");

    // R2 subtract going negative
    s.add_op = OP_SUB;
    step(s, {16'h0000, 16'h0010, 16'h8000, 16'h0005}, {16'h0001, 16'h0020, 16'h0001, 16'h0005}, '0, "R2");

    // R3 signed compare, flag pattern 0101 then 1010
    s.add_op = OP_SLT;
    step(s, {16'h0001, 16'h8000, 16'h7FFF, 16'hFFFF}, {16'h8000, 16'h0001, 16'h8000, 16'h0000}, '0, "R3");
    step(s, {16'h8000, 16'h0005, 16'hFFFE, 16'h0007}, {16'h7FFF, 16'h0005, 16'hFFFF, 16'h0007}, '0, "R3");

    // R10 flag clears on non-compare op
    s.add_op = OP_ADD;
    step(s, {16'h0001, 16'h0001, 16'h0001, 16'h0001}, {16'h0002, 16'h0002, 16'h0002, 16'h0002}, '0, "R10");

    // R4 lane number
    s.add_op = OP_IDX;
    step(s, {16'h1111, 16'h2222, 16'h3333, 16'h4444}, {16'h5555, 16'h6666, 16'h7777, 16'h8888}, '0, "R4");

    // R6 broadcast scalar, with vector B on the other multiplier input
    s = '0; s.add_op = OP_ADD;
    s.src[P_ADD_A] = sel(OUT_BC, LOC_EXT); s.src[P_ADD_B] = sel(OUT_ZERO, LOC_EXT);
    s.src[P_MUL_A] = sel(OUT_BC, LOC_EXT); s.src[P_MUL_B] = sel(OUT_VB, LOC_EXT);
    step(s, {16'h9999, 16'h8888, 16'h7777, 16'h6666}, {16'h0004, 16'h0003, 16'h0002, 16'h0001}, 16'hA5C3, "R6");

    // R7 zero select on every input
    s.src[P_ADD_A] = sel(OUT_ZERO, LOC_EXT); s.src[P_MUL_A] = sel(OUT_ZERO, LOC_EXT);
    s.src[P_MUL_B] = sel(OUT_ZERO, LOC_EXT);
    step(s, {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}, {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}, 16'hFFFF, "R7");

    // R9 write entry 2 from A and read it back; write entry 1 from B
    s = '0; s.rf_we = 1'b1; s.rf_waddr = 2'd2; s.rf_raddr = 2'd2;
    s.src[P_RF_WD] = sel(OUT_VA, LOC_EXT);
    step(s, {16'hD003, 16'hC002, 16'hB001, 16'hA000}, '0, '0, "R9");
    s.rf_waddr = 2'd1; s.rf_raddr = 2'd1; s.src[P_RF_WD] = sel(OUT_VB, LOC_EXT);
    step(s, '0, {16'h4444, 16'h3333, 16'h2222, 16'h1111}, '0, "R9");
    // R9 no write when disabled, other data on the write operand
    s.rf_we = 1'b0; s.rf_waddr = 2'd2; s.rf_raddr = 2'd2; s.src[P_RF_WD] = sel(OUT_VA, LOC_EXT);
    step(s, {16'hEEEE, 16'hEEEE, 16'hEEEE, 16'hEEEE}, '0, '0, "R9");
    s.rf_raddr = 2'd1;
    step(s, {16'hEEEE, 16'hEEEE, 16'hEEEE, 16'hEEEE}, '0, '0, "R9");

    // R8 local feedback: seed, then chain lane-private paths
    s = '0; s.add_op = OP_IDX;
    s.src[P_MUL_A] = sel(OUT_VA, LOC_EXT); s.src[P_MUL_B] = sel(OUT_VB, LOC_EXT);
    step(s, {16'h0007, 16'h0005, 16'h0003, 16'h0002}, {16'h0003, 16'h0003, 16'h0003, 16'h0003}, '0, "R8");
    s = '0; s.add_op = OP_ADD; s.rf_raddr = 2'd2; s.rf_we = 1'b1; s.rf_waddr = 2'd3;
    s.src[P_ADD_A] = sel(OUT_VB, LOC_ADD); s.src[P_ADD_B] = sel(OUT_ZERO, LOC_RF);
    s.src[P_MUL_A] = sel(OUT_VB, LOC_MUL); s.src[P_MUL_B] = sel(OUT_VA, LOC_ADD);
    s.src[P_RF_WD] = sel(OUT_VA, LOC_MUL);
    step(s, {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}, {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}, 16'hFFFF, "R8");
    s.rf_raddr = 2'd3;
    step(s, '0, '0, '0, "R8");
    s.add_op = OP_SUB;
    step(s, '0, '0, '0, "R8");

    repeat (3) @(posedge clk);
    #5;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule